// File: doc/BRIEF.md
# Feistel Round-Key Schedule Generator

This block produces the round keys for a bit-sliced Feistel cipher core. It holds a 96-bit key as two halves of six 8-bit words, a left half and a right half. On each accepted step it computes a small nonlinear mix of one half and XORs the result into the other half. The mix uses the running round count as a constant and places its outputs one word further on. The cipher core reads both halves after every step as its round key material.

A run starts with a load, which sets the round count to 1 and the ascending phase. While ascending, each step uses the current count and then increments it. The step taken at the midpoint count does not apply that count. Instead it moves the block into the descending phase and applies the count minus one. Every step after that first decrements the count and then applies the new value. The run ends after the step that applies count 1. From then on, steps are ignored until the next load. The source half is fixed by the parity of the applied count, so the roles of the halves reverse when the phase turns. Words are packed with word i at bits [8i+7:8i] of each half.

Top module: `ksched_top`

## Requirements
- R1: After reset, both key halves read zero, `roundCnt` reads 1 and `descPhase` reads 0.
- R2: A cycle with `loadKey` high captures `loadLeft` and `loadRight` into the halves, sets `roundCnt` to 1, clears `descPhase` and arms the block. All outputs show this on the following cycle.
- R3: A `stepKey` pulse given after reset but before any load changes no output.
- R4: A step that applies an odd count c takes the right half as source and XORs the mix into the left half. The right half stays unchanged.
- R5: A step that applies an even count c takes the left half as source and XORs the mix into the right half. The left half stays unchanged.
- R6: The mix of source words s0..s5 with count c works as follows. First, x = (s0 + c mod 256) ^ (s2 & s1), y = s1 ^ (s2 & x), z = s2 ^ (y | x). The bench XORs x rotated right by one bit into target word 1, y into word 2, and z rotated left by one bit into word 3. Second, the same three formulas are applied to s3, s4, s5 with no constant added, and the results go into target words 4, 5 and 0. Word i is at bits [8i+7:8i].
- R7: In the ascending phase, a step below the midpoint count 47 applies the current count and then raises `roundCnt` by 1.
- R8: A step taken at count 47 in the ascending phase sets `descPhase`, applies count 46 with the left half as source, and leaves `roundCnt` at 46.
- R9: In the descending phase, each step lowers `roundCnt` by 1 and applies the lowered value.
- R10: After the descending step that applies count 1, `roundCnt` stays at 1 and further steps change no output until the next load.
- R11: When `loadKey` and `stepKey` are both high in the same cycle, the load wins and no key update is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loadKey | input | 1 | Capture a new key and restart the count |
| stepKey | input | 1 | Advance the schedule by one step |
| loadLeft | input | 48 | Left key half to load |
| loadRight | input | 48 | Right key half to load |
| keyLeft | output | 48 | Current left key half |
| keyRight | output | 48 | Current right key half |
| roundCnt | output | 8 | Current round count |
| descPhase | output | 1 | 1 while the descending phase is active |

## Verification
The assertions check the counter on every cycle: it steps up by one while ascending, turns at the midpoint, steps down while descending, and rests at 1 whenever the block is not armed. On every cycle they also check that a step alters at most one half and that a load takes effect in full. Only the bench's scenarios can show that the key values themselves are correct. For that, a reference model follows full ascending and descending runs for several keys. The bench also confirms by hand the first step from an all-zero key, and covers the pulses that must be ignored before a load and after a run has ended.

// File: rtl/ksched_pkg.sv
package ksched_pkg;

  typedef enum logic {
    PH_ASC  = 1'b0,
    PH_DESC = 1'b1
  } schedPhase_e;

  // strobes from the control to the key datapath
  typedef struct packed {
    logic loadKey;
    logic applyStep;
    logic srcRight;
  } schedCmd_t;

endpackage

// File: rtl/ksched_path.sv
module ksched_path
  import ksched_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 6,
  localparam int HALF_W   = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  schedCmd_t         cmd,
  input  logic [WORD_W-1:0] stepConst,
  input  logic [HALF_W-1:0] loadLeft,
  input  logic [HALF_W-1:0] loadRight,
  output logic [HALF_W-1:0] keyLeft,
  output logic [HALF_W-1:0] keyRight
);

  localparam int NUM_GROUPS = NUM_WORDS / 3;

  logic [HALF_W-1:0] keyLeftQ, keyRightQ;
  logic [HALF_W-1:0] srcHalf, mixMask;
  logic [HALF_W-1:0] groupMask [NUM_GROUPS];

  assign srcHalf = cmd.srcRight ? keyRightQ : keyLeftQ;

  // one three-word bit-sliced substitution per group; outputs land one word on
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    localparam int T0 = ((3*g + 1) % NUM_WORDS) * WORD_W;
    localparam int T1 = ((3*g + 2) % NUM_WORDS) * WORD_W;
    localparam int T2 = ((3*g + 3) % NUM_WORDS) * WORD_W;
    logic [WORD_W-1:0] in0, in1, in2, aV, bV, cV;

    if (g == 0) begin : gConst
      assign in0 = srcHalf[3*g*WORD_W +: WORD_W] + stepConst;
    end else begin : gPlain
      assign in0 = srcHalf[3*g*WORD_W +: WORD_W];
    end
    assign in1 = srcHalf[(3*g+1)*WORD_W +: WORD_W];
    assign in2 = srcHalf[(3*g+2)*WORD_W +: WORD_W];

    assign aV = in0 ^ (in2 & in1);
    assign bV = in1 ^ (in2 & aV);
    assign cV = in2 ^ (bV | aV);

    assign groupMask[g] = (HALF_W'({aV[0], aV[WORD_W-1:1]}) << T0)
                        | (HALF_W'(bV) << T1)
                        | (HALF_W'({cV[WORD_W-2:0], cV[WORD_W-1]}) << T2);
  end

  always_comb begin
    mixMask = '0;
    for (int k = 0; k < NUM_GROUPS; k++) mixMask = mixMask | groupMask[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      keyLeftQ  <= '0;
      keyRightQ <= '0;
    end else if (cmd.loadKey) begin
      keyLeftQ  <= loadLeft;
      keyRightQ <= loadRight;
    end else if (cmd.applyStep) begin
      if (cmd.srcRight) keyLeftQ  <= keyLeftQ ^ mixMask;
      else              keyRightQ <= keyRightQ ^ mixMask;
    end
  end

  assign keyLeft  = keyLeftQ;
  assign keyRight = keyRightQ;

endmodule

// File: rtl/ksched_ctrl.sv
module ksched_ctrl
  import ksched_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MID_CNT = 47
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadReq,
  input  logic             stepReq,
  output schedCmd_t        cmd,
  output logic [CNT_W-1:0] stepConst,
  output logic [CNT_W-1:0] roundCnt,
  output logic             descPhase,
  output logic             armed
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(MID_CNT);

  logic [CNT_W-1:0] cntQ, useCnt;
  schedPhase_e      phaseQ;
  logic             armedQ, takeStep, atMid, countDown;

  assign takeStep  = stepReq & ~loadReq & armedQ;
  assign atMid     = (phaseQ == PH_ASC) && (cntQ == CNT_MID);
  assign countDown = (phaseQ == PH_DESC) || atMid;
  assign useCnt    = countDown ? cntQ - CNT_ONE : cntQ;

  always_comb begin
    cmd.loadKey   = loadReq;
    cmd.applyStep = takeStep;
    cmd.srcRight  = useCnt[0];
  end
  assign stepConst = useCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ   <= CNT_ONE;
      phaseQ <= PH_ASC;
      armedQ <= 1'b0;
    end else if (loadReq) begin
      cntQ   <= CNT_ONE;
      phaseQ <= PH_ASC;
      armedQ <= 1'b1;
    end else if (takeStep) begin
      if (!countDown) begin
        cntQ <= cntQ + CNT_ONE;
      end else begin
        cntQ   <= useCnt;
        phaseQ <= PH_DESC;
        if (useCnt == CNT_ONE) armedQ <= 1'b0;
      end
    end
  end

  assign roundCnt  = cntQ;
  assign descPhase = (phaseQ == PH_DESC);
  assign armed     = armedQ;

endmodule

// File: rtl/ksched_top.sv
module ksched_top
  import ksched_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 6,
  parameter int MID_CNT   = 47,
  localparam int HALF_W   = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadKey,
  input  logic              stepKey,
  input  logic [HALF_W-1:0] loadLeft,
  input  logic [HALF_W-1:0] loadRight,
  output logic [HALF_W-1:0] keyLeft,
  output logic [HALF_W-1:0] keyRight,
  output logic [WORD_W-1:0] roundCnt,
  output logic              descPhase
);

  schedCmd_t         cmd;
  logic [WORD_W-1:0] stepConst;
  logic              stepArmed;

  ksched_ctrl #(.CNT_W(WORD_W), .MID_CNT(MID_CNT)) uCtrl (
    .clk(clk), .rst(rst), .loadReq(loadKey), .stepReq(stepKey),
    .cmd(cmd), .stepConst(stepConst), .roundCnt(roundCnt),
    .descPhase(descPhase), .armed(stepArmed)
  );

  ksched_path #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) uPath (
    .clk(clk), .rst(rst), .cmd(cmd), .stepConst(stepConst),
    .loadLeft(loadLeft), .loadRight(loadRight),
    .keyLeft(keyLeft), .keyRight(keyRight)
  );

endmodule

// File: rtl/ksched_checker.sv
module ksched_checker #(
  parameter int CNT_W   = 8,
  parameter int HALF_W  = 48,
  parameter int MID_CNT = 47
) (
  input logic              clk,
  input logic              rst,
  input logic              loadKey,
  input logic              stepKey,
  input logic              armed,
  input logic [HALF_W-1:0] loadLeft,
  input logic [HALF_W-1:0] loadRight,
  input logic [HALF_W-1:0] keyLeft,
  input logic [HALF_W-1:0] keyRight,
  input logic [CNT_W-1:0]  roundCnt,
  input logic              descPhase
);

  logic stepTaken;
  assign stepTaken = stepKey && !loadKey && armed;

  // R2 and R11: a load overrides any step
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    loadKey |=> (keyLeft == $past(loadLeft)) && (keyRight == $past(loadRight))
                && (roundCnt == CNT_W'(1)) && !descPhase);

  assert_unarmed_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!armed && !loadKey) |=> $stable(keyLeft) && $stable(keyRight)
                             && $stable(roundCnt) && $stable(descPhase));

  // R4 and R5: the source half never changes
  assert_one_half_R4: assert property (@(posedge clk) disable iff (rst)
    stepTaken |=> $stable(keyLeft) || $stable(keyRight));

  assert_cnt_up_R7: assert property (@(posedge clk) disable iff (rst)
    (stepTaken && !descPhase && roundCnt != CNT_W'(MID_CNT))
      |=> (roundCnt == $past(roundCnt) + CNT_W'(1)) && !descPhase);

  assert_mid_turn_R8: assert property (@(posedge clk) disable iff (rst)
    (stepTaken && !descPhase && roundCnt == CNT_W'(MID_CNT))
      |=> descPhase && (roundCnt == CNT_W'(MID_CNT - 1)));

  assert_cnt_down_R9: assert property (@(posedge clk) disable iff (rst)
    (stepTaken && descPhase) |=> descPhase && (roundCnt == $past(roundCnt) - CNT_W'(1)));

  assert_rest_cnt_R10: assert property (@(posedge clk) disable iff (rst)
    !armed |-> roundCnt == CNT_W'(1));

endmodule

bind ksched_top ksched_checker #(.CNT_W(WORD_W), .HALF_W(HALF_W), .MID_CNT(MID_CNT)) uChk (
  .clk(clk), .rst(rst), .loadKey(loadKey), .stepKey(stepKey), .armed(stepArmed),
  .loadLeft(loadLeft), .loadRight(loadRight), .keyLeft(keyLeft), .keyRight(keyRight),
  .roundCnt(roundCnt), .descPhase(descPhase)
);

// File: tb/tb_ksched_top.sv
module tb_ksched_top;

  localparam int CLK_PERIOD = 10;
  localparam int MID = 47;

  // stimulus: {left half, right half}; expected keys come from the model below
  localparam logic [95:0] VECS [4] = '{
    96'h000000000000_000000000000,
    96'h000000000000_000000000001,
    96'hFFFFFFFFFFFF_FFFFFFFFFFFF,
    96'h0123456789AB_FEDCBA987654
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadKey = 1'b0;
  logic        stepKey = 1'b0;
  logic [47:0] loadLeft = '0;
  logic [47:0] loadRight = '0;
  logic [47:0] keyLeft, keyRight;
  logic [7:0]  roundCnt;
  logic        descPhase;

  int checks = 0;
  int fails = 0;

  logic [47:0] mL, mR;
  logic [7:0]  mCnt;
  logic        mDesc, mArmed;

  always #(CLK_PERIOD/2) clk = ~clk;

  ksched_top dut (
    .clk(clk), .rst(rst), .loadKey(loadKey), .stepKey(stepKey),
    .loadLeft(loadLeft), .loadRight(loadRight),
    .keyLeft(keyLeft), .keyRight(keyRight),
    .roundCnt(roundCnt), .descPhase(descPhase)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R6 reference mix, written per word
  function automatic logic [47:0] mixOf(input logic [47:0] s, input logic [7:0] c);
    logic [7:0] w [6];
    logic [7:0] t [6];
    logic [7:0] x, y, z;
    logic [47:0] r;
    for (int i = 0; i < 6; i++) begin
      w[i] = s[8*i +: 8];
      t[i] = 8'h00;
    end
    x = (w[0] + c) ^ (w[1] & w[2]);
    y = w[1] ^ (x & w[2]);
    z = w[2] ^ (x | y);
    t[1] = {x[0], x[7:1]};
    t[2] = y;
    t[3] = {z[6:0], z[7]};
    x = w[3] ^ (w[4] & w[5]);
    y = w[4] ^ (x & w[5]);
    z = w[5] ^ (x | y);
    t[4] = {x[0], x[7:1]};
    t[5] = y;
    t[0] = {z[6:0], z[7]};
    for (int i = 0; i < 6; i++) r[8*i +: 8] = t[i];
    return r;
  endfunction

  task automatic doLoad(input logic [47:0] l, input logic [47:0] r, input logic alsoStep);
    @(negedge clk);
    loadKey = 1'b1; stepKey = alsoStep; loadLeft = l; loadRight = r;
    @(negedge clk);
    loadKey = 1'b0; stepKey = 1'b0;
    mL = l; mR = r; mCnt = 8'd1; mDesc = 1'b0; mArmed = 1'b1;
  endtask

  task automatic doStep();
    @(negedge clk);
    stepKey = 1'b1;
    @(negedge clk);
    stepKey = 1'b0;
  endtask

  task automatic printSummary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    printSummary();
    $finish;
  end

  initial begin
    string kTag, cTag;
    logic [7:0] useC;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 keyLeft", 64'(keyLeft), 64'h0);
    check("R1 keyRight", 64'(keyRight), 64'h0);
    check("R1 roundCnt", 64'(roundCnt), 64'd1);
    check("R1 descPhase", 64'(descPhase), 64'd0);

    // R3 step before any load is ignored
    doStep();
    check("R3 keyLeft", 64'(keyLeft), 64'h0);
    check("R3 keyRight", 64'(keyRight), 64'h0);
    check("R3 roundCnt", 64'(roundCnt), 64'd1);

    // R11 load with a simultaneous step: load wins
    doLoad(48'h112233445566, 48'hA0B0C0D0E0F0, 1'b1);
    check("R11 keyLeft", 64'(keyLeft), 64'h112233445566);
    check("R11 keyRight", 64'(keyRight), 64'hA0B0C0D0E0F0);
    check("R11 roundCnt", 64'(roundCnt), 64'd1);

    // R6 hand-worked first step from an all-zero key (count 1, right to left)
    doLoad(48'h0, 48'h0, 1'b0);
    doStep();
    check("R6 first step keyLeft", 64'(keyLeft), 64'h000002008000);
    check("R4 first step keyRight", 64'(keyRight), 64'h0);
    check("R7 first step roundCnt", 64'(roundCnt), 64'd2);

    // full runs against the model for each vector
    for (int v = 0; v < 4; v++) begin
      doLoad(VECS[v][95:48], VECS[v][47:0], 1'b0);
      check("R2 keyLeft", 64'(keyLeft), 64'(mL));
      check("R2 keyRight", 64'(keyRight), 64'(mR));
      check("R2 roundCnt", 64'(roundCnt), 64'd1);
      check("R2 descPhase", 64'(descPhase), 64'd0);
      for (int s = 0; s < 2 * (MID - 1) + 2; s++) begin
        if (!mArmed) begin
          kTag = "R10 keys"; cTag = "R10 roundCnt";
        end else begin
          if (!mDesc && mCnt != 8'(MID)) begin
            useC = mCnt; mCnt = mCnt + 8'd1; cTag = "R7 roundCnt";
          end else begin
            cTag = mDesc ? "R9 roundCnt" : "R8 roundCnt";
            mCnt = mCnt - 8'd1; useC = mCnt; mDesc = 1'b1;
          end
          if (useC[0]) begin
            mL = mL ^ mixOf(mR, useC); kTag = "R4/R6 keys";
          end else begin
            mR = mR ^ mixOf(mL, useC); kTag = "R5/R6 keys";
          end
          if (mDesc && useC == 8'd1) mArmed = 1'b0;
        end
        doStep();
        check(kTag, 64'(keyLeft), 64'(mL));
        check(kTag, 64'(keyRight), 64'(mR));
        check(cTag, 64'(roundCnt), 64'(mCnt));
        check(cTag, 64'(descPhase), 64'(mDesc));
      end
    end

    printSummary();
    $finish;
  end

endmodule